// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the device side of a byte-wide mailbox between a host and an embedded controller. The host sees two locations. Offset 0x00 is the data port. Offset 0x04 returns a status byte when read and takes a command byte when written. Every byte the host writes is latched and raises an input-full flag. The flag drops a fixed, parameterised number of clocks later, when the controller consumes the byte. An output-full flag tells the host that the data port holds a byte for it.

The bytes the host writes drive a small command sequencer. A read command is followed by an address byte, and the controller then fetches that location of an internal 256-byte register space into the data port. A write command is followed by an address byte and then a value byte, which is stored at that address. Two further commands switch a burst indicator on and off. The register space sits behind a synchronous single-port memory with a one-clock read latency.

The host is expected to poll status. It writes only when input-full is clear, and it reads the data port only after output-full is set.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte reads 0x00 and the data port reads 0x00.
- R2: Only offsets 0x00 (data) and 0x04 (command on write, status on read) are decoded. A write to any other offset has no effect, and a read of any other offset returns 0x00.
- R3: An accepted host write sets input-full (status bit 1) at the capturing clock edge, and it is cleared exactly IBF_LAT clocks later, when the byte is consumed.
- R4: Status bit 3 is 1 when the last accepted host write went to the command offset, and 0 when it went to the data offset.
- R5: After command 0x80 and one address byte, the data port is loaded with that register's value and output-full (status bit 0) rises one clock after input-full falls for the address byte.
- R6: Output-full stays set until the host reads the data port, and a data-port read clears it at that clock edge.
- R7: Command 0x81 followed by an address byte and a value byte stores the value at that address. All 256 locations hold independent values.
- R8: Command 0x82 sets the burst flag (status bit 4) and command 0x83 clears it. The other status bits (7:5 and 2) read 0.
- R9: A host write that arrives while input-full is set is dropped. It changes neither status bit 3 nor the command sequence in progress.
- R10: A data-port byte consumed while no command is pending is ignored. No register changes and output-full stays clear.
- R11: An unrecognised command code returns the sequencer to idle, so the data bytes that follow it are ignored.
- R12: A command consumed in the middle of a sequence abandons that sequence and starts the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | HOST_AW (3) | Host byte offset |
| host_wr | input | 1 | Host write strobe, one clock per byte |
| host_rd | input | 1 | Host read strobe; at the data offset it clears output-full |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte or data byte for the addressed offset, combinational |

## Verification
The bench counts clocks across the input-full window and the output-full rise, so an off-by-one in the consume timer or a missing fetch stage shows up as a status byte in the wrong cycle. It writes and reads back all 256 register locations with an arithmetic pattern, which exposes address truncation or aliasing. It injects a byte while input-full is set, a stray data byte while idle, an unknown command followed by would-be address and value bytes, and a command that interrupts another. Each of these leaves a footprint in the register space or in status that a read-back would reveal: a corrupted location, a spurious output-full, or a data byte taken as an address. A write to an undecoded offset must leave input-full clear.

// File: rtl/ec_host_pkg.sv
package ec_host_pkg;

    localparam int BYTE_W = 8;

    // command codes
    localparam logic [BYTE_W-1:0] CMD_READ      = 8'h80;
    localparam logic [BYTE_W-1:0] CMD_WRITE     = 8'h81;
    localparam logic [BYTE_W-1:0] CMD_BURST_ON  = 8'h82;
    localparam logic [BYTE_W-1:0] CMD_BURST_OFF = 8'h83;

    // status bit positions
    localparam int ST_OBF     = 0;
    localparam int ST_IBF     = 1;
    localparam int ST_LASTCMD = 3;
    localparam int ST_BURST   = 4;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_RD_ADDR,
        SEQ_RD_FETCH,
        SEQ_WR_ADDR,
        SEQ_WR_DATA
    } seq_state_e;

    typedef struct packed {
        logic              is_cmd;
        logic [BYTE_W-1:0] val;
    } host_byte_t;

    typedef struct packed {
        logic              we;
        logic              re;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } rf_req_t;

    function automatic logic [BYTE_W-1:0] pack_status(input logic obf,
                                                      input logic ibf,
                                                      input logic last_cmd,
                                                      input logic burst);
        logic [BYTE_W-1:0] s;
        s = '0;
        s[ST_OBF]     = obf;
        s[ST_IBF]     = ibf;
        s[ST_LASTCMD] = last_cmd;
        s[ST_BURST]   = burst;
        return s;
    endfunction

endpackage

// File: rtl/ec_regfile.sv
module ec_regfile
    import ec_host_pkg::*;
#(
    parameter int AW = BYTE_W
) (
    input  logic              clk,
    input  rf_req_t           req,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (req.we) begin
            mem_q[req.addr[AW-1:0]] <= req.wdata;
        end
        if (req.re) begin
            rdata <= mem_q[req.addr[AW-1:0]];
        end
    end

endmodule

// File: rtl/ec_host_if.sv
module ec_host_if
    import ec_host_pkg::*;
#(
    parameter int HOST_AW  = 3,
    parameter int IBF_LAT  = 4,
    parameter int DATA_OFS = 0,
    parameter int CMD_OFS  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [BYTE_W-1:0]  host_wdata,
    output logic [BYTE_W-1:0]  host_rdata,
    input  logic               burst_i,
    input  logic               load_i,
    input  logic [BYTE_W-1:0]  load_data_i,
    output logic               consume_o,
    output host_byte_t         byte_o,
    output logic               ibf_o,
    output logic               obf_o,
    output logic               last_cmd_o,
    output logic               wr_accept_o,
    output logic               data_rd_o
);
    localparam int CNT_W = $clog2(IBF_LAT + 1);

    logic             sel_data, sel_cmd;
    logic             ibf_q, obf_q, last_cmd_q;
    logic [CNT_W-1:0] cnt_q;
    host_byte_t       held_q;
    logic [BYTE_W-1:0] dout_q;

    assign sel_data    = (host_addr == HOST_AW'(DATA_OFS));
    assign sel_cmd     = (host_addr == HOST_AW'(CMD_OFS));
    assign wr_accept_o = host_wr && (sel_data || sel_cmd) && !ibf_q;
    assign consume_o   = ibf_q && (cnt_q == CNT_W'(1));
    assign data_rd_o   = host_rd && sel_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ibf_q      <= 1'b0;
            cnt_q      <= '0;
            held_q     <= '0;
            last_cmd_q <= 1'b0;
        end else if (wr_accept_o) begin
            ibf_q      <= 1'b1;
            cnt_q      <= CNT_W'(IBF_LAT);
            held_q     <= '{is_cmd: sel_cmd, val: host_wdata};
            last_cmd_q <= sel_cmd;
        end else if (consume_o) begin
            ibf_q <= 1'b0;
            cnt_q <= '0;
        end else if (ibf_q) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            obf_q  <= 1'b0;
            dout_q <= '0;
        end else if (load_i) begin
            obf_q  <= 1'b1;
            dout_q <= load_data_i;
        end else if (data_rd_o) begin
            obf_q <= 1'b0;
        end
    end

    always_comb begin
        if (sel_cmd) begin
            host_rdata = pack_status(obf_q, ibf_q, last_cmd_q, burst_i);
        end else if (sel_data) begin
            host_rdata = dout_q;
        end else begin
            host_rdata = '0;
        end
    end

    assign byte_o     = held_q;
    assign ibf_o      = ibf_q;
    assign obf_o      = obf_q;
    assign last_cmd_o = last_cmd_q;

endmodule

// File: rtl/ec_cmd_seq.sv
module ec_cmd_seq
    import ec_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              consume_i,
    input  host_byte_t        byte_i,
    output rf_req_t           rf_req_o,
    input  logic [BYTE_W-1:0] rf_rdata_i,
    output logic              load_o,
    output logic [BYTE_W-1:0] load_data_o,
    output logic              burst_o
);
    seq_state_e        state_q, state_d;
    logic [BYTE_W-1:0] addr_q, addr_d;
    logic              burst_q, burst_d;

    always_comb begin
        state_d  = state_q;
        addr_d   = addr_q;
        burst_d  = burst_q;
        rf_req_o = '0;
        load_o   = 1'b0;

        if (state_q == SEQ_RD_FETCH) begin
            load_o  = 1'b1;
            state_d = SEQ_IDLE;
        end

        if (consume_i) begin
            if (byte_i.is_cmd) begin
                case (byte_i.val)
                    CMD_READ:      state_d = SEQ_RD_ADDR;
                    CMD_WRITE:     state_d = SEQ_WR_ADDR;
                    CMD_BURST_ON:  begin burst_d = 1'b1; state_d = SEQ_IDLE; end
                    CMD_BURST_OFF: begin burst_d = 1'b0; state_d = SEQ_IDLE; end
                    default:       state_d = SEQ_IDLE;
                endcase
            end else begin
                case (state_q)
                    SEQ_RD_ADDR: begin
                        rf_req_o.re   = 1'b1;
                        rf_req_o.addr = byte_i.val;
                        state_d       = SEQ_RD_FETCH;
                    end
                    SEQ_WR_ADDR: begin
                        addr_d  = byte_i.val;
                        state_d = SEQ_WR_DATA;
                    end
                    SEQ_WR_DATA: begin
                        rf_req_o.we    = 1'b1;
                        rf_req_o.addr  = addr_q;
                        rf_req_o.wdata = byte_i.val;
                        state_d        = SEQ_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            addr_q  <= '0;
            burst_q <= 1'b0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            burst_q <= burst_d;
        end
    end

    assign load_data_o = rf_rdata_i;
    assign burst_o     = burst_q;

endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
    import ec_host_pkg::*;
#(
    parameter int HOST_AW = 3,
    parameter int IBF_LAT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [BYTE_W-1:0]  host_wdata,
    output logic [BYTE_W-1:0]  host_rdata
);
    localparam int DATA_OFS = 0;
    localparam int CMD_OFS  = 4;

    logic              consume, ibf, obf, last_cmd, wr_accept, data_rd;
    logic              load, burst;
    logic [BYTE_W-1:0] load_data, rf_rdata;
    host_byte_t        cur_byte;
    rf_req_t           rf_req;
    logic              mem_we;

    assign mem_we = rf_req.we;

    ec_host_if #(
        .HOST_AW (HOST_AW),
        .IBF_LAT (IBF_LAT),
        .DATA_OFS(DATA_OFS),
        .CMD_OFS (CMD_OFS)
    ) u_if (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .burst_i    (burst),
        .load_i     (load),
        .load_data_i(load_data),
        .consume_o  (consume),
        .byte_o     (cur_byte),
        .ibf_o      (ibf),
        .obf_o      (obf),
        .last_cmd_o (last_cmd),
        .wr_accept_o(wr_accept),
        .data_rd_o  (data_rd)
    );

    ec_cmd_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .consume_i  (consume),
        .byte_i     (cur_byte),
        .rf_req_o   (rf_req),
        .rf_rdata_i (rf_rdata),
        .load_o     (load),
        .load_data_o(load_data),
        .burst_o    (burst)
    );

    ec_regfile #(.AW(BYTE_W)) u_rf (
        .clk  (clk),
        .req  (rf_req),
        .rdata(rf_rdata)
    );

endmodule

// File: rtl/ec_host_port_chk.sv
module ec_host_port_chk #(
    parameter int IBF_LAT = 4
) (
    input logic clk,
    input logic rst,
    input logic host_wr,
    input logic wr_accept,
    input logic consume,
    input logic ibf,
    input logic obf,
    input logic last_cmd,
    input logic load,
    input logic data_rd,
    input logic mem_we
);
    localparam int HC_W = $clog2(IBF_LAT + 2);

    logic [HC_W-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
        end else if (wr_accept) begin
            hi_cnt <= HC_W'(1);
        end else if (ibf && hi_cnt < HC_W'(IBF_LAT + 1)) begin
            hi_cnt <= hi_cnt + HC_W'(1);
        end
    end

    a_r3_ibf_on_accept: assert property (@(posedge clk) disable iff (rst)
        wr_accept |=> ibf);

    a_r3_ibf_window: assert property (@(posedge clk) disable iff (rst)
        (ibf && hi_cnt == HC_W'(IBF_LAT)) |=> !ibf);

    a_r3_ibf_bound: assert property (@(posedge clk) disable iff (rst)
        ibf |-> (hi_cnt <= HC_W'(IBF_LAT)));

    a_r5_load_sets_obf: assert property (@(posedge clk) disable iff (rst)
        load |=> obf);

    a_r6_read_clears_obf: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !load) |=> !obf);

    a_r7_store_on_consume: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> consume);

    a_r9_busy_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (host_wr && ibf) |=> $stable(last_cmd));

endmodule

bind ec_host_port ec_host_port_chk #(.IBF_LAT(IBF_LAT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .host_wr  (host_wr),
    .wr_accept(wr_accept),
    .consume  (consume),
    .ibf      (ibf),
    .obf      (obf),
    .last_cmd (last_cmd),
    .load     (load),
    .data_rd  (data_rd),
    .mem_we   (mem_we)
);

// File: tb/ec_host_port_tb.sv
`timescale 1ns/1ps
module ec_host_port_tb;

    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] host_addr = 3'd4;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ec_host_port #(.HOST_AW(3), .IBF_LAT(LAT)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 37 + 5);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic get_status(output logic [7:0] s);
        host_addr = 3'd4;
        #1;
        s = host_rdata;
    endtask

    task automatic wait_ibf_clear();
        logic [7:0] s;
        get_status(s);
        while (s[1]) begin
            @(negedge clk);
            get_status(s);
        end
    endtask

    task automatic wait_obf();
        logic [7:0] s;
        get_status(s);
        while (!s[0]) begin
            @(negedge clk);
            get_status(s);
        end
    endtask

    task automatic raw_write(input logic [2:0] ofs, input logic [7:0] v);
        host_addr  = ofs;
        host_wdata = v;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic do_write(input logic [2:0] ofs, input logic [7:0] v);
        wait_ibf_clear();
        @(negedge clk);
        raw_write(ofs, v);
    endtask

    task automatic read_data(output logic [7:0] v);
        host_addr = 3'd0;
        host_rd   = 1'b1;
        #1;
        v = host_rdata;
        @(negedge clk);
        host_rd   = 1'b0;
    endtask

    task automatic ec_write(input logic [7:0] a, input logic [7:0] v);
        do_write(3'd4, 8'h81);
        do_write(3'd0, a);
        do_write(3'd0, v);
    endtask

    task automatic ec_read(input logic [7:0] a, output logic [7:0] v);
        do_write(3'd4, 8'h80);
        do_write(3'd0, a);
        wait_obf();
        read_data(v);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] s, v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        get_status(s);
        chk("R1 status", s, 8'h00);
        host_addr = 3'd0; #1;
        chk("R1 data", host_rdata, 8'h00);

        // R3 / R4 flag timing on a write command
        wait_ibf_clear();
        @(negedge clk);
        raw_write(3'd4, 8'h81);
        get_status(s);
        chk("R4 cmd bit with R3 ibf set", s, 8'h0A);
        repeat (LAT - 1) @(negedge clk);
        get_status(s);
        chk("R3 ibf held", s, 8'h0A);
        @(negedge clk);
        get_status(s);
        chk("R3 ibf cleared", s, 8'h08);
        do_write(3'd0, 8'h00);
        get_status(s);
        chk("R4 data bit", s, 8'h02);
        do_write(3'd0, 8'hC3);

        // R5 read timing
        do_write(3'd4, 8'h80);
        wait_ibf_clear();
        @(negedge clk);
        raw_write(3'd0, 8'h00);
        repeat (LAT - 1) @(negedge clk);
        get_status(s);
        chk("R5 ibf still set", s, 8'h02);
        @(negedge clk);
        get_status(s);
        chk("R5 obf not yet", s, 8'h00);
        @(negedge clk);
        get_status(s);
        chk("R5 obf set", s, 8'h01);
        repeat (10) @(negedge clk);
        get_status(s);
        chk("R6 obf held until read", s, 8'h01);
        read_data(v);
        chk("R5 data value", v, 8'hC3);
        get_status(s);
        chk("R6 obf cleared by read", s, 8'h00);

        // R7 full sweep
        for (int a = 0; a < 256; a++) ec_write(8'(a), pat(a));
        for (int a = 0; a < 256; a++) begin
            ec_read(8'(a), v);
            chk("R7 sweep", v, pat(a));
        end

        // R8 burst
        do_write(3'd4, 8'h82);
        wait_ibf_clear();
        get_status(s);
        chk("R8 burst on", s, 8'h18);
        do_write(3'd4, 8'h83);
        wait_ibf_clear();
        get_status(s);
        chk("R8 burst off", s, 8'h08);

        // R9 write while busy
        do_write(3'd4, 8'h81);
        raw_write(3'd0, 8'h77);
        get_status(s);
        chk("R9 cmd bit kept", s, 8'h0A);
        do_write(3'd0, 8'h40);
        do_write(3'd0, 8'h9E);
        ec_read(8'h40, v);
        chk("R9 sequence intact", v, 8'h9E);
        ec_read(8'h77, v);
        chk("R9 dropped byte unused", v, pat(8'h77));

        // R10 stray data while idle
        do_write(3'd0, 8'h12);
        wait_ibf_clear();
        repeat (3) @(negedge clk);
        get_status(s);
        chk("R10 no obf", s, 8'h00);
        ec_read(8'h12, v);
        chk("R10 register unchanged", v, pat(8'h12));

        // R11 unknown command
        do_write(3'd4, 8'h99);
        do_write(3'd0, 8'h21);
        wait_ibf_clear();
        repeat (3) @(negedge clk);
        get_status(s);
        chk("R11 no obf", s, 8'h00);
        do_write(3'd4, 8'h81);
        do_write(3'd4, 8'h99);
        do_write(3'd0, 8'h33);
        do_write(3'd0, 8'h44);
        ec_read(8'h33, v);
        chk("R11 write sequence dropped", v, pat(8'h33));

        // R12 abort
        do_write(3'd4, 8'h81);
        do_write(3'd0, 8'h50);
        do_write(3'd4, 8'h80);
        do_write(3'd0, 8'h50);
        wait_obf();
        read_data(v);
        chk("R12 write aborted by read", v, pat(8'h50));
        do_write(3'd4, 8'h80);
        do_write(3'd4, 8'h81);
        do_write(3'd0, 8'h60);
        do_write(3'd0, 8'hAB);
        wait_ibf_clear();
        repeat (3) @(negedge clk);
        get_status(s);
        chk("R12 read aborted no obf", s, 8'h00);
        ec_read(8'h60, v);
        chk("R12 new write applied", v, 8'hAB);

        // R2 undecoded offset
        @(negedge clk);
        raw_write(3'd2, 8'h81);
        get_status(s);
        chk("R2 other offset write ignored", s, 8'h00);
        host_addr = 3'd2; #1;
        chk("R2 other offset reads zero", host_rdata, 8'h00);

        summary();
        $finish;
    end

endmodule